// File: doc/BRIEF.md
# Multiplexed LED Digit Scanner

This block drives a multi-digit LED segment display that has one common terminal per digit. It lights one digit at a time and steps through every digit in a fixed frame. A hardware cycle counter sets the timing, so the refresh rate does not drift. Each digit slot begins with a blanking gap in which every segment and every digit select is off. This keeps one digit's pattern from showing on the next digit. After the gap the digit is lit for an on-time that depends on its position, and the digit then stays dark for the rest of the slot. A 4-bit brightness code scales only the lit part of the slot. The blanking gap and the frame period do not change with brightness.

Segment patterns are written through a valid/ready port into a back buffer. The scanner only ever reads a separate front buffer. A commit request marks the back buffer as ready. At the next frame boundary the whole back buffer is copied into the front buffer at once, so no frame ever shows a mix of old and new digits. The slot length is derived as `CLK_HZ / (FRAME_HZ * DIGITS)` cycles. The default frame rate of 100 Hz is well above the 50 Hz flicker limit. A one-cycle `frame_start_o` pulse marks the first cycle of digit 0.

Top module: `mux_display_scanner`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every digit select and every segment is at its off level, and the scan is at digit 0, slot cycle 0.
- R2: `frame_start_o` is high exactly on the cycles where the frame position is 0. Frames are `DIGITS*SLOT_CYC` cycles long, with `SLOT_CYC = CLK_HZ/(FRAME_HZ*DIGITS)`.
- R3: Digits are scanned in ascending order 0..DIGITS-1, one slot each per frame. At most one digit select is active at any time, and the active select never moves straight from one digit to another.
- R4: In slot cycles 0..BLANK_CYC-1 of every slot, all segment lines and all digit selects are at their off level.
- R5: The lit window starts at slot cycle BLANK_CYC and lasts `floor(on(d)*bright/15)` cycles. Here `on(d) = ON_BASE + FIRST_EXTRA` for digit 0 and `ON_BASE` for every other digit. Outside the lit window the outputs are off.
- R6: A brightness code of 0 keeps every output off for the whole frame, and the frame timing continues.
- R7: With the default active-low polarity, a lit digit d drives `dig_o[d]=0` and `seg_o = ~front[d]`, where bit i of the stored pattern lights segment i. The off level is all ones on both buses.
- R8: An accepted write (`wr_valid_i && wr_ready_o`) updates only the back buffer at `wr_addr_i`. Writes to addresses at or above DIGITS are dropped. Without a commit, the displayed patterns never change.
- R9: A commit pulse sets a pending flag. On the last cycle of the next frame that ends with the flag set, the whole back buffer is copied to the front buffer, and the flag clears unless a new commit arrives in that same cycle. The new patterns appear from the next `frame_start_o`.
- R10: A write accepted in the same cycle as a swap goes into the back buffer only. It reaches the display only after a later commit and frame end.
- R11: `wr_ready_o` is always 1, so the write port never applies back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_valid_i | input | 1 | Write request for one digit pattern |
| wr_ready_o | output | 1 | Write accepted; tied high |
| wr_addr_i | input | $clog2(DIGITS) | Digit index of the write |
| wr_data_i | input | SEG_W | Segment pattern, 1 = segment lit |
| commit_i | input | 1 | Request a back-to-front swap at the next frame end |
| bright_i | input | 4 | Brightness code, 0 = off, 15 = full on-time |
| seg_o | output | SEG_W | Segment lines (polarity set by SEG_ACT_LOW) |
| dig_o | output | DIGITS | Digit selects (polarity set by DIG_ACT_LOW) |
| frame_start_o | output | 1 | Pulse on the first cycle of digit 0 |

## Verification
Embedded assertions check on every cycle the properties that hold at all times:
- at most one digit select is active;
- the select never jumps straight from one digit to another;
- the outputs are off on a frame start and at brightness 0;
- each frame end is followed by a frame start;
- the front buffer changes only right after a frame end;
- the write port is always ready.

The bench's reference model is needed for the timing and data behaviour. It checks the exact length of each lit window per position and brightness, and the segment values of each digit. It also checks that patterns stay hidden until a commit and a frame boundary, and that a write landing on the swap cycle stays in the back buffer.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int BRIGHT_W   = 4;
  localparam int BRIGHT_MAX = (1 << BRIGHT_W) - 1;
  typedef logic [BRIGHT_W-1:0] bright_t;
endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import scan_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SLOT_CYC    = 125000,
  parameter int BLANK_CYC   = 50,
  parameter int ON_BASE     = 100000,
  parameter int FIRST_EXTRA = 10000,
  localparam int CW = $clog2(SLOT_CYC),
  localparam int DW = $clog2(DIGITS)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  bright_t       bright_i,
  output logic [DW-1:0] digit_o,
  output logic          lit_o,
  output logic          frame_start_o,
  output logic          frame_end_o
);
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dig_q;
  logic          slot_end;
  int unsigned   on_full, on_len;

  assign slot_end    = (int'(cnt_q) == SLOT_CYC - 1);
  assign frame_end_o = slot_end && (int'(dig_q) == DIGITS - 1);
  assign frame_start_o = !rst_i && (cnt_q == '0) && (dig_q == '0);
  assign digit_o     = dig_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      dig_q <= '0;
    end else if (slot_end) begin
      cnt_q <= '0;
      dig_q <= (int'(dig_q) == DIGITS - 1) ? '0 : dig_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    on_full = (dig_q == '0) ? unsigned'(ON_BASE + FIRST_EXTRA) : unsigned'(ON_BASE);
    on_len  = (on_full * 32'(bright_i)) / unsigned'(BRIGHT_MAX);
    lit_o   = (int'(cnt_q) >= BLANK_CYC) &&
              (32'(cnt_q) < unsigned'(BLANK_CYC) + on_len);
  end

  // R2
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_end_o |=> frame_start_o);
endmodule

// File: rtl/disp_buffer.sv
module disp_buffer #(
  parameter int DIGITS = 4,
  parameter int SEG_W  = 8,
  localparam int DW = $clog2(DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_addr_i,
  input  logic [SEG_W-1:0] wr_data_i,
  input  logic             commit_i,
  input  logic             frame_end_i,
  input  logic [DW-1:0]    rd_addr_i,
  output logic [SEG_W-1:0] rd_data_o
);
  logic [SEG_W-1:0] back_q  [DIGITS];
  logic [SEG_W-1:0] front_q [DIGITS];
  logic             pend_q;
  logic             swap;

  assign swap      = frame_end_i && pend_q;
  assign rd_data_o = front_q[rd_addr_i];

  always_ff @(posedge clk_i) begin
    if (rst_i) pend_q <= 1'b0;
    else if (commit_i) pend_q <= 1'b1;
    else if (swap) pend_q <= 1'b0;
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        back_q[g]  <= '0;
        front_q[g] <= '0;
      end else begin
        if (swap) front_q[g] <= back_q[g];
        if (wr_en_i && (int'(wr_addr_i) == g)) back_q[g] <= wr_data_i;
      end
    end

    // R9
    front_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(front_q[g]) |-> $past(frame_end_i));
  end

  // R9
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (swap && !commit_i) |=> !pend_q);
endmodule

// File: rtl/mux_display_scanner.sv
module mux_display_scanner
  import scan_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SEG_W       = 8,
  parameter int CLK_HZ      = 50_000_000,
  parameter int FRAME_HZ    = 100,
  parameter int BLANK_CYC   = 50,
  parameter int ON_BASE     = 100000,
  parameter int FIRST_EXTRA = 10000,
  parameter bit SEG_ACT_LOW = 1'b1,
  parameter bit DIG_ACT_LOW = 1'b1,
  localparam int SLOT_CYC = CLK_HZ / (FRAME_HZ * DIGITS),
  localparam int DW = $clog2(DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [DW-1:0]    wr_addr_i,
  input  logic [SEG_W-1:0] wr_data_i,
  input  logic             commit_i,
  input  logic [3:0]       bright_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [DIGITS-1:0] dig_o,
  output logic             frame_start_o
);
  logic [DW-1:0]     digit;
  logic              lit, frame_end;
  logic [SEG_W-1:0]  pattern;
  logic [DIGITS-1:0] act;
  logic [SEG_W-1:0]  seg_on;

  assign wr_ready_o = 1'b1;

  scan_timer #(
    .DIGITS(DIGITS), .SLOT_CYC(SLOT_CYC), .BLANK_CYC(BLANK_CYC),
    .ON_BASE(ON_BASE), .FIRST_EXTRA(FIRST_EXTRA)
  ) u_timer (
    .clk_i(clk_i), .rst_i(rst_i), .bright_i(bright_i),
    .digit_o(digit), .lit_o(lit),
    .frame_start_o(frame_start_o), .frame_end_o(frame_end)
  );

  disp_buffer #(.DIGITS(DIGITS), .SEG_W(SEG_W)) u_buf (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_valid_i && wr_ready_o), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .commit_i(commit_i),
    .frame_end_i(frame_end), .rd_addr_i(digit), .rd_data_o(pattern)
  );

  always_comb begin
    act = '0;
    if (lit) act[digit] = 1'b1;
    seg_on = lit ? pattern : '0;
  end

  assign dig_o = act ^ {DIGITS{DIG_ACT_LOW}};
  assign seg_o = seg_on ^ {SEG_W{SEG_ACT_LOW}};

  // R3
  one_digit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(dig_o ^ {DIGITS{DIG_ACT_LOW}}));
  // R3
  no_direct_hop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((|(dig_o ^ {DIGITS{DIG_ACT_LOW}})) && (|$past(dig_o ^ {DIGITS{DIG_ACT_LOW}})))
      |-> $stable(dig_o));
  // R4
  start_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |-> (seg_o == {SEG_W{SEG_ACT_LOW}} && dig_o == {DIGITS{DIG_ACT_LOW}}));
  // R6
  dark_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (bright_i == '0) |-> (dig_o == {DIGITS{DIG_ACT_LOW}}));
  // R11
  always_ready_chk: assert property (@(posedge clk_i) wr_ready_o);
endmodule

// File: tb/mux_display_scanner_bench.sv
module mux_display_scanner_bench;
  localparam int N = 4, SW = 8, CHZ = 4000, FHZ = 50;
  localparam int BL = 2, OB = 12, FX = 4;
  localparam int SLOT = CHZ / (FHZ * N);
  localparam int F = SLOT * N;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          wr_valid = 1'b0, commit = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [SW-1:0] wr_data = '0;
  logic [3:0]    bright = 4'd15;
  logic          wr_ready, fs;
  logic [SW-1:0] seg;
  logic [N-1:0]  dig;

  mux_display_scanner #(
    .DIGITS(N), .SEG_W(SW), .CLK_HZ(CHZ), .FRAME_HZ(FHZ), .BLANK_CYC(BL),
    .ON_BASE(OB), .FIRST_EXTRA(FX), .SEG_ACT_LOW(1'b1), .DIG_ACT_LOW(1'b1)
  ) u_mux_display_scanner (
    .clk_i(clk), .rst_i(rst), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .commit_i(commit),
    .bright_i(bright), .seg_o(seg), .dig_o(dig), .frame_start_o(fs)
  );

  int checks = 0, errors = 0;
  string scen = "R1";

  // Reference model state, built from R8..R10
  logic [SW-1:0] m_front [N];
  logic [SW-1:0] m_back  [N];
  bit m_pend = 1'b0;
  int ph = 0;

  initial for (int k = 0; k < N; k++) begin m_front[k] = '0; m_back[k] = '0; end

  always @(posedge clk) begin
    if (!rst) begin
      if ((ph % F) == F - 1 && m_pend)
        for (int k = 0; k < N; k++) m_front[k] = m_back[k];
      if (commit) m_pend = 1'b1;
      else if ((ph % F) == F - 1) m_pend = 1'b0;
      if (wr_valid) m_back[wr_addr] = wr_data;
      ph = ph + 1;
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at ph %0d",
               tag, scen, what, act, exp, ph);
    end
  endtask

  function automatic int lit_len(int d, int br);
    return ((d == 0 ? OB + FX : OB) * br) / 15;
  endfunction

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      automatic int pos = ph % F;
      automatic int d = pos / SLOT;
      automatic int c = pos % SLOT;
      automatic bit lit = (c >= BL) && (c < BL + lit_len(d, bright));
      automatic logic [N-1:0] e_dig = lit ? ~(N'(1) << d) : '1;
      automatic logic [SW-1:0] e_seg = lit ? ~m_front[d] : '1;
      automatic string tag = (c < BL) ? "R4" : (bright == 0) ? "R6" : "R3 R5 R7";
      chk(dig == e_dig, tag, "dig_o", dig, e_dig);
      chk(seg == e_seg, tag, "seg_o", seg, e_seg);
      chk(fs == (pos == 0), "R2", "frame_start_o", fs, pos == 0);
      chk(wr_ready == 1'b1, "R11", "wr_ready_o", wr_ready, 1);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    wr_valid = 1'b1; wr_addr = 2'(a); wr_data = SW'(d);
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic do_commit();
    commit = 1'b1; tick(); commit = 1'b0;
  endtask

  task automatic frames(int n);
    repeat (n * F) tick();
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (4) tick();
    chk(dig == '1, "R1", "dig_o in reset", dig, 8'hf);
    chk(seg == '1, "R1", "seg_o in reset", seg, 8'hff);
    chk(fs == 1'b0, "R1", "frame_start in reset", fs, 0);
    @(negedge clk); rst = 1'b0; #1;
    chk(dig == '1 && seg == '1, "R1", "outputs after release", {dig, seg}, 12'hfff);
    frames(1);

    scen = "R7";
    for (int k = 0; k < N; k++) wr(k, $urandom);
    do_commit();
    frames(3);

    scen = "R8";
    for (int k = 0; k < N; k++) wr(k, $urandom);
    wr_valid = 1'b1; wr_addr = 2'd3; wr_data = 8'h5a; tick(); wr_valid = 1'b0;
    frames(2);

    scen = "R9";
    do_commit();
    frames(2);

    scen = "R10";
    for (int k = 0; k < N; k++) wr(k, $urandom);
    do_commit();
    while ((ph % F) != F - 1) tick();
    wr_valid = 1'b1; wr_addr = 2'd0; wr_data = 8'hc3; tick(); wr_valid = 1'b0;
    frames(2);
    do_commit();
    frames(2);

    scen = "R6";
    bright = 4'd0; frames(2);
    bright = 4'd7; frames(2);
    bright = 4'd1; frames(1);
    bright = 4'd15;

    scen = "R5";
    repeat (30 * F) begin
      wr_valid = ($urandom % 4) == 0;
      wr_addr  = 2'($urandom);
      wr_data  = SW'($urandom);
      commit   = ($urandom % 60) == 0;
      if (($urandom % 150) == 0) bright = 4'($urandom);
      tick();
    end
    wr_valid = 1'b0; commit = 1'b0;
    frames(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule